// File: doc/BRIEF.md
# Pipelined Memory Test Access Port

This block gives a memory self-test engine a path into a group of up to eleven cache RAM arrays without adding any logic in series with the functional path. The test access is one more leg on the multiplexers that already sit in front of each array. A single test-select input gives that leg priority over every functional source. Address, write data, write enable and a one-hot array enable are then steered into the arrays through a fixed pipeline.

Every access takes five clock cycles from issue to read data. Each behavioural array row holds four 64-bit doublewords. A read returns the whole row. The 64-bit word that reaches the output is picked by a 13-bit read-control input. The driver presents on that input a delayed copy of the read's array enables and doubleword select, timed to match the pipeline. When test select is low, the functional inputs reach the arrays unchanged and the test inputs are ignored.

Top module: `memtest_port`

## Requirements
- R1: A read issued in clock cycle k (inputs sampled at the edge ending cycle k) drives its word on `rd_data` from the rising edge that ends cycle k+4 onward, five edges after issue, as long as `rd_ctl` is driven as described in R6.
- R2: `tst_ce` selects array i when bit i is set. At most one bit may be set in any cycle while `tst_on` is high.
- R3: While `tst_on` is high, the arrays take the test inputs and ignore all functional inputs, even when a functional write targets the same location.
- R4: A write (`tst_we`=1 with one enable bit set) stores `tst_wdata` into the enabled array at row `tst_addr[4:2]` and doubleword `tst_addr[1:0]`. A read issued in the very next cycle returns the new value.
- R5: `tst_addr[1:0]` selects which of the four doublewords of a row is written. Writing one doubleword leaves the other three of that row unchanged.
- R6: `rd_ctl` is `{array enables[10:0], doubleword[1:0]}` of the read issued four cycles earlier. It is all zeros for write or idle cycles. It picks the array and doubleword that drive `rd_data`.
- R7: `rd_data` is all zeros in the cycle after one in which `rd_ctl[12:2]` is all zeros.
- R8: Arrays 8, 9 and 10 are 32 bits wide. They store only `wdata[31:0]`, and their reads return zeros in `rd_data[63:32]`.
- R9: While `tst_on` is low, `fn_ce`, `fn_we`, `fn_addr` and `fn_wdata` reach the arrays with the same timing as the test inputs. Test inputs then have no effect on array contents.
- R10: `rst_n` low clears every pipeline register and `rd_data` at once, without waiting for a clock edge. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tst_on | input | 1 | Test select, priority over functional sources |
| tst_ce | input | 11 | One-hot test array enable |
| tst_we | input | 1 | Test write enable, global |
| tst_addr | input | 18 | Test address; [1:0] doubleword select |
| tst_wdata | input | 64 | Test write data |
| fn_ce | input | 11 | Functional array enable |
| fn_we | input | 1 | Functional write enable |
| fn_addr | input | 18 | Functional address |
| fn_wdata | input | 64 | Functional write data |
| rd_ctl | input | 13 | Delayed {enables, doubleword} for read steering |
| rd_data | output | 64 | Selected read word |

## Verification
The bench goes after back-to-back reads that alternate between arrays. A design with one stage too many or too few would return the neighbour's word, and the bench would see that word. Read-after-write to the same location is checked next: a write landing late would return the stale value. A doubleword-lane mix-up would corrupt the sibling words of a row. A missing zero-extension on the 32-bit arrays would leak bits into the upper half. A functional write made during test mode, or a test write made outside test mode, would change what a later read returns. An asynchronous reset in the middle of a run must clear the output right away.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int NARR     = 11;
  localparam int DW       = 64;
  localparam int AW       = 18;
  localparam int LANES    = 4;
  localparam int DSEL_W   = $clog2(LANES);
  localparam int ROW_AW   = 3;
  localparam int NARROW_0 = 8;
  localparam int NARROW_W = 32;
  localparam int CTL_W    = NARR + DSEL_W;

  typedef struct packed {
    logic [NARR-1:0] ce;
    logic            we;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   wd;
  } acc_t;

  function automatic int arr_width(input int idx);
    return (idx >= NARROW_0) ? NARROW_W : DW;
  endfunction
endpackage

// File: rtl/mtp_inmux.sv
module mtp_inmux
  import mtp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tst_on,
  input  acc_t tst_in,
  input  acc_t fn_in,
  output acc_t arr_q
);
  logic on_q;
  acc_t t_q, f_q, arr_d;

  // stage 2 source pick: test leg wins when selected
  always_comb begin
    arr_d = f_q;
    if (on_q) arr_d = tst_in_q_sel();
  end

  function automatic acc_t tst_in_q_sel();
    return t_q;
  endfunction

  // stage 1 capture and stage 2 array-side register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      t_q   <= '0;
      f_q   <= '0;
      arr_q <= '0;
    end else begin
      on_q  <= tst_on;
      t_q   <= tst_in;
      f_q   <= fn_in;
      arr_q <= arr_d;
    end
  end

  // R2
  ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_on |-> $onehot0(tst_in.ce));

  // R3
  tst_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(tst_on, 2)) |-> (arr_q == $past(tst_in, 2)));

  // R9
  fn_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && !$past(tst_on, 2)) |-> (arr_q == $past(fn_in, 2)));
endmodule

// File: rtl/mtp_ram.sv
module mtp_ram #(
  parameter int W      = 64,
  parameter int ROW_AW = 3,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce,
  input  logic                      we,
  input  logic [ROW_AW-1:0]         row,
  input  logic [$clog2(LANES)-1:0]  lane,
  input  logic [W-1:0]              wd,
  output logic [LANES*W-1:0]        row_q
);
  localparam int ROWS = 1 << ROW_AW;
  localparam int RW   = LANES * W;

  logic [RW-1:0] mem [ROWS];
  logic [RW-1:0] rd_q, rd_d;
  logic          wr_en, rd_en;

  assign wr_en = ce & we;
  assign rd_en = ce & ~we;

  // array storage, lane-masked write, clock enable = wr_en
  always_ff @(posedge clk) begin
    if (wr_en) mem[row][int'(lane)*W +: W] <= wd;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = mem[row];
  end

  // stage 3 read register, stage 4 output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      row_q <= '0;
    end else begin
      rd_q  <= rd_d;
      row_q <= rd_q;
    end
  end
endmodule

// File: rtl/mtp_rdsel.sv
module mtp_rdsel
  import mtp_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CTL_W-1:0]               rd_ctl,
  input  logic [NARR-1:0][LANES*DW-1:0]  rows,
  output logic [DW-1:0]                  rd_data
);
  logic [DW-1:0]     sel_d;
  logic [DSEL_W-1:0] dsel;

  assign dsel = rd_ctl[DSEL_W-1:0];

  always_comb begin
    sel_d = '0;
    for (int a = 0; a < NARR; a++) begin
      if (rd_ctl[DSEL_W+a]) sel_d = sel_d | rows[a][int'(dsel)*DW +: DW];
    end
  end

  // stage 5 output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= sel_d;
  end

  // R6
  ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_ctl[CTL_W-1:DSEL_W]));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl[CTL_W-1:DSEL_W] == '0) |=> (rd_data == '0));
endmodule

// File: rtl/memtest_port.sv
module memtest_port
  import mtp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_on,
  input  logic [NARR-1:0]   tst_ce,
  input  logic              tst_we,
  input  logic [AW-1:0]     tst_addr,
  input  logic [DW-1:0]     tst_wdata,
  input  logic [NARR-1:0]   fn_ce,
  input  logic              fn_we,
  input  logic [AW-1:0]     fn_addr,
  input  logic [DW-1:0]     fn_wdata,
  input  logic [CTL_W-1:0]  rd_ctl,
  output logic [DW-1:0]     rd_data
);
  acc_t tst_in, fn_in, arr_q;
  logic [NARR-1:0][LANES*DW-1:0] rows_all;

  assign tst_in = '{ce: tst_ce, we: tst_we, addr: tst_addr, wd: tst_wdata};
  assign fn_in  = '{ce: fn_ce,  we: fn_we,  addr: fn_addr,  wd: fn_wdata};

  mtp_inmux u_inmux (
    .clk    (clk),
    .rst_n  (rst_n),
    .tst_on (tst_on),
    .tst_in (tst_in),
    .fn_in  (fn_in),
    .arr_q  (arr_q)
  );

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    localparam int W = arr_width(a);
    logic [LANES*W-1:0] row_w;

    mtp_ram #(.W(W), .ROW_AW(ROW_AW), .LANES(LANES)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (arr_q.ce[a]),
      .we    (arr_q.we),
      .row   (arr_q.addr[DSEL_W+ROW_AW-1:DSEL_W]),
      .lane  (arr_q.addr[DSEL_W-1:0]),
      .wd    (arr_q.wd[W-1:0]),
      .row_q (row_w)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign rows_all[a][l*DW +: DW] = DW'(row_w[l*W +: W]);
    end
  end

  mtp_rdsel u_rdsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_ctl  (rd_ctl),
    .rows    (rows_all),
    .rd_data (rd_data)
  );
endmodule

// File: tb/test_memtest_port.sv
module test_memtest_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tst_on, tst_we, fn_we;
  logic [10:0] tst_ce, fn_ce;
  logic [17:0] tst_addr, fn_addr;
  logic [63:0] tst_wdata, fn_wdata, rd_data;
  logic [12:0] rd_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] model [11][8][4];
  logic [12:0] h_ctl [6];
  logic [63:0] h_exp [6];
  logic        h_chk [6];
  string       h_rq  [6];

  logic [10:0] nf_ce;
  logic        nf_we;
  logic [17:0] nf_addr;
  logic [63:0] nf_wd;

  // read table: {array[3:0], row[0], doubleword[1:0]} (row 0 or 1)
  localparam logic [6:0] RD_TAB [16] = '{
    {4'd0, 1'b0, 2'd0}, {4'd5, 1'b1, 2'd3}, {4'd0, 1'b0, 2'd1}, {4'd10, 1'b1, 2'd2},
    {4'd3, 1'b0, 2'd2}, {4'd7, 1'b1, 2'd1}, {4'd9, 1'b0, 2'd3}, {4'd1, 1'b1, 2'd0},
    {4'd2, 1'b0, 2'd1}, {4'd8, 1'b1, 2'd2}, {4'd4, 1'b1, 2'd3}, {4'd6, 1'b0, 2'd0},
    {4'd10, 1'b0, 2'd0}, {4'd0, 1'b1, 2'd3}, {4'd5, 1'b0, 2'd2}, {4'd9, 1'b1, 2'd1}
  };

  memtest_port i_memtest_port (
    .clk(clk), .rst_n(rst_n), .tst_on(tst_on), .tst_ce(tst_ce), .tst_we(tst_we),
    .tst_addr(tst_addr), .tst_wdata(tst_wdata), .fn_ce(fn_ce), .fn_we(fn_we),
    .fn_addr(fn_addr), .fn_wdata(fn_wdata), .rd_ctl(rd_ctl), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] msk(input int a);
    return (a >= 8) ? 64'h0000_0000_FFFF_FFFF : '1;
  endfunction

  function automatic logic [63:0] pat(input int a, input int r, input int l);
    return {8'(a), 8'(r), 8'(l), 8'hC3, 8'(~a), 8'(r + l), 8'h5A, 8'(a * 3 + l)};
  endfunction

  function automatic logic [17:0] adr(input int r, input int l);
    return 18'((r << 2) | l);
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one issue cycle; checks the access issued five cycles earlier
  task automatic acc(input logic on, input logic [10:0] ce, input logic we,
                     input logic [17:0] ad, input logic [63:0] wd,
                     input logic chk, input logic [63:0] ex, input string rq);
    @(negedge clk);
    for (int i = 5; i > 0; i--) begin
      h_ctl[i] = h_ctl[i-1]; h_exp[i] = h_exp[i-1];
      h_chk[i] = h_chk[i-1]; h_rq[i]  = h_rq[i-1];
    end
    h_ctl[0] = (we || !on) ? 13'd0 : {ce, ad[1:0]};
    h_exp[0] = ex; h_chk[0] = chk; h_rq[0] = rq;
    if (h_chk[5]) check(rd_data, h_exp[5], h_rq[5]);
    tst_on = on; tst_ce = ce; tst_we = we; tst_addr = ad; tst_wdata = wd;
    fn_ce = nf_ce; fn_we = nf_we; fn_addr = nf_addr; fn_wdata = nf_wd;
    nf_ce = '0; nf_we = 1'b0; nf_addr = '0; nf_wd = '0;
    rd_ctl = h_ctl[4];
    if (on && we) begin
      for (int a = 0; a < 11; a++)
        if (ce[a]) model[a][ad[4:2]][ad[1:0]] = wd & msk(a);
    end
  endtask

  task automatic wr(input int a, input int r, input int l, input logic [63:0] v);
    acc(1'b1, 11'(1 << a), 1'b1, adr(r, l), v, 1'b0, '0, "");
  endtask

  task automatic rd(input int a, input int r, input int l, input string rq);
    acc(1'b1, 11'(1 << a), 1'b0, adr(r, l), '0, 1'b1, model[a][r][l], rq);
  endtask

  task automatic idle(input int n, input logic chk);
    for (int i = 0; i < n; i++) acc(1'b1, '0, 1'b0, '0, '0, chk, '0, "R7 idle zero");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tst_on = 0; tst_ce = '0; tst_we = 0; tst_addr = '0; tst_wdata = '0;
    fn_ce = '0; fn_we = 0; fn_addr = '0; fn_wdata = '0; rd_ctl = '0;
    nf_ce = '0; nf_we = 0; nf_addr = '0; nf_wd = '0;
    for (int i = 0; i < 6; i++) begin h_ctl[i] = '0; h_exp[i] = '0; h_chk[i] = 0; h_rq[i] = ""; end
    repeat (3) @(negedge clk);
    check(rd_data, '0, "R10 reset state");
    rst_n = 1'b1;

    // fill rows 0,1,3 of every array, every doubleword
    for (int a = 0; a < 11; a++)
      for (int r = 0; r < 4; r++)
        for (int l = 0; l < 4; l++)
          if (r != 2) wr(a, r, l, pat(a, r, l));
    idle(6, 1'b1);

    // table walk: back-to-back reads alternating arrays (R1, R5, R6, R8)
    for (int t = 0; t < 16; t++)
      rd(int'(RD_TAB[t][6:3]), int'(RD_TAB[t][2]), int'(RD_TAB[t][1:0]), "R1/R5/R6 table read");
    idle(6, 1'b1);

    // R4: read immediately after write, same location; R5 sibling lanes intact
    wr(6, 1, 2, 64'hDEAD_BEEF_0123_4567);
    rd(6, 1, 2, "R4 read after write");
    rd(6, 1, 1, "R5 sibling lane 1");
    rd(6, 1, 3, "R5 sibling lane 3");
    idle(6, 1'b0);

    // R8: narrow array keeps low 32 bits only
    wr(10, 0, 1, '1);
    rd(10, 0, 1, "R8 narrow upper zero");
    check(model[10][0][1], 64'h0000_0000_FFFF_FFFF, "R8 narrow model");
    idle(6, 1'b0);

    // R3: functional write to same location while test mode owns the arrays
    nf_ce = 11'(1 << 4); nf_we = 1'b1; nf_addr = adr(3, 0); nf_wd = 64'h1111_2222_3333_4444;
    wr(4, 3, 0, 64'hAAAA_5555_AAAA_5555);
    idle(2, 1'b0);
    rd(4, 3, 0, "R3 test priority");
    idle(6, 1'b0);

    // R9: functional path used, test write ignored
    nf_ce = 11'(1 << 2); nf_we = 1'b1; nf_addr = adr(3, 1); nf_wd = 64'hF00D_F00D_F00D_F00D;
    acc(1'b0, 11'(1 << 3), 1'b1, adr(3, 1), 64'h7777_7777_7777_7777, 1'b0, '0, "");
    model[2][3][1] = 64'hF00D_F00D_F00D_F00D;
    rd(2, 3, 1, "R9 functional write lands");
    rd(3, 3, 1, "R9 test write ignored");
    idle(6, 1'b1);

    // R10: asynchronous reset mid-run
    rd(1, 0, 2, "");
    rd(7, 1, 0, "");
    idle(3, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rd_data, '0, "R10 async clear");
    for (int i = 0; i < 6; i++) h_chk[i] = 0;
    repeat (2) @(negedge clk);
    check(rd_data, '0, "R10 held in reset");
    rst_n = 1'b1;
    rd(7, 1, 0, "R10 contents kept");
    idle(6, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule